// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block keeps one private write-back cache coherent with its peers on a shared snooping bus. It uses write-invalidate. It holds a small direct-mapped array of lines. Each line has a tag, a coherence state and one data word, and the state is Invalid, Shared (clean, read-only, memory up to date) or Exclusive (the only copy, writable, dirty). On the processor side it takes read and write requests. Hits are served locally. A miss is turned into a bus transaction.

Every transaction the other caches place on the bus is looked up in the same array. When the local cache holds the only valid copy of a line, it supplies that data and downgrades or drops the line. The bus is atomic and carries one transaction at a time. A requester raises a request, and it owns the bus in the single cycle its grant is high. In that cycle the controller drives a command, an address and data, and it samples the fill data. A dirty victim that conflicts with the new address is written back before the miss is issued. If a snoop changes the line that a waiting miss depends on, the request is withdrawn and decided again from the new line state.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. The ready output is high, and bus request, response valid and snoop supply are low.
- R2: A read that finds its line Invalid or holding another tag (with no dirty victim) issues a read miss (command 2'b01) with the request address. It returns the word sampled on bus_rdata in the grant cycle and leaves the line Shared.
- R3: A write that finds its line Invalid issues a write miss (command 2'b10) with the request address, stores the write data and leaves the line Exclusive.
- R4: A write that hits a Shared line issues a write miss for that address and then holds the line Exclusive with the new data.
- R5: A read or write whose line is Exclusive under another tag first issues a write-back (command 2'b11) carrying the victim's address and data. It then issues the miss for the new address.
- R6: A snooped write miss (2'b10) matching a Shared line makes it Invalid without supplying data.
- R7: A snooped read miss (2'b01) matching an Exclusive line raises snoop_supply with the line's data in that same cycle and leaves the line Shared.
- R8: A snooped write miss matching an Exclusive line raises snoop_supply with the line's data and leaves the line Invalid.
- R9: If a snoop changes the target line while a bus request waits for grant, the request is dropped and the miss is decided again. A victim that is no longer dirty is not written back.
- R10: In any cycle with a snoop command other than 2'b00, processor requests are not accepted: ready is low, and a pending lookup waits.
- R11: Read hits in Shared or Exclusive and write hits in Exclusive cause no bus request. A response is a one-cycle pulse two cycles after the accepting edge.
- R12: bus_cmd is 2'b00 except in a cycle where bus_req and bus_gnt are both high. A raised bus_req stays high until it is granted or withdrawn by R9.
- R13: A snoop whose tag does not match, and a snooped read miss on a Shared line, leave the line and the outputs unchanged, with no data supplied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Request address; low IDX_W bits select the line |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_req_ready | output | 1 | Request accepted at the next edge when valid |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Read data, or the written word for writes |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Grant; the transaction occupies this cycle |
| bus_cmd | output | 2 | 00 none, 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_rdata | input | DATA_W | Fill data, sampled in the grant cycle of a read miss |
| snoop_cmd | input | 2 | Another agent's bus command, same encoding |
| snoop_addr | input | ADDR_W | Another agent's bus address |
| snoop_supply | output | 1 | This cache supplies the data for the snooped miss |
| snoop_data | output | DATA_W | Supplied line data |

## Verification
The assertions take the bus to be atomic. A grant is never given in a cycle that also carries a snooped command, because the snoop belongs to another owner's transaction. Grants also arrive only while a request is raised. The bench acts as arbiter and as the other caches. It grants only after it sees bus_req and after a chosen delay, and it places snoops only in cycles where it does not grant. It drives both from the falling edge, so the snoop that forces a restart lands in a waiting cycle and never beside a grant.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'b00,
        LN_SHR = 2'b01,
        LN_EXC = 2'b10
    } line_state_e;

    typedef enum logic [1:0] {
        BC_NONE   = 2'b00,
        BC_RDMISS = 2'b01,
        BC_WRMISS = 2'b10,
        BC_WBACK  = 2'b11
    } bus_cmd_e;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_LOOKUP,
        PS_WBREQ,
        PS_MISSREQ
    } proc_state_e;

endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
    import msi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output line_state_e       a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_state_e       b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  line_state_e       wr_state,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    line_state_e       st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i]   <= LN_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_idx]   <= wr_state;
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  bus_cmd_e          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_state_e       ln_state,
    input  logic [TAG_W-1:0]  ln_tag,
    input  logic [DATA_W-1:0] ln_data,
    output logic              upd_en,
    output line_state_e       upd_state,
    output logic              supply,
    output logic [DATA_W-1:0] sup_data
);
    logic match;

    always_comb begin
        match     = (ln_state != LN_INV) && (ln_tag == snp_tag);
        upd_en    = 1'b0;
        upd_state = ln_state;
        supply    = 1'b0;
        case (snp_cmd)
            BC_RDMISS: begin
                // dirty owner hands its copy over and keeps a clean one
                if (match && ln_state == LN_EXC) begin
                    upd_en    = 1'b1;
                    upd_state = LN_SHR;
                    supply    = 1'b1;
                end
            end
            BC_WRMISS: begin
                if (match) begin
                    upd_en    = 1'b1;
                    upd_state = LN_INV;
                    supply    = (ln_state == LN_EXC);
                end
            end
            default: ;
        endcase
        sup_data = supply ? ln_data : '0;
    end

endmodule

// File: rtl/msi_proc_fsm.sv
module msi_proc_fsm
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cpu_req_valid,
    input  logic                    cpu_req_write,
    input  logic [ADDR_W-1:0]       cpu_req_addr,
    input  logic [DATA_W-1:0]       cpu_req_wdata,
    output logic                    cpu_req_ready,
    output logic                    cpu_resp_valid,
    output logic [DATA_W-1:0]       cpu_resp_rdata,
    input  logic                    snoop_busy,
    input  logic                    snoop_upd,
    input  logic [IDX_W-1:0]        snoop_idx,
    output logic [IDX_W-1:0]        look_idx,
    input  line_state_e             ln_state,
    input  logic [ADDR_W-IDX_W-1:0] ln_tag,
    input  logic [DATA_W-1:0]       ln_data,
    input  logic                    bus_gnt,
    input  logic [DATA_W-1:0]       bus_rdata,
    output logic                    bus_req,
    output bus_cmd_e                bus_cmd,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [DATA_W-1:0]       bus_wdata,
    output logic                    wr_en,
    output line_state_e             wr_state,
    output logic [ADDR_W-IDX_W-1:0] wr_tag,
    output logic [DATA_W-1:0]       wr_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        proc_state_e       st;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              resp;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic [TAG_W-1:0] req_tag;
    logic             hit;
    logic             restart;

    assign look_idx = q.addr[IDX_W-1:0];
    assign req_tag  = q.addr[ADDR_W-1:IDX_W];

    always_comb begin
        d         = q;
        d.resp    = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = BC_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        wr_en     = 1'b0;
        wr_state  = ln_state;
        wr_tag    = ln_tag;
        wr_data   = ln_data;

        cpu_req_ready = (q.st == PS_IDLE) && !snoop_busy;
        hit     = (ln_state != LN_INV) && (ln_tag == req_tag);
        restart = snoop_upd && (snoop_idx == look_idx);

        case (q.st)
            PS_IDLE: begin
                if (cpu_req_valid && cpu_req_ready) begin
                    d.st    = PS_LOOKUP;
                    d.wr    = cpu_req_write;
                    d.addr  = cpu_req_addr;
                    d.wdata = cpu_req_wdata;
                end
            end
            PS_LOOKUP: begin
                if (!snoop_busy) begin
                    if (hit && (!q.wr || ln_state == LN_EXC)) begin
                        d.st    = PS_IDLE;
                        d.resp  = 1'b1;
                        d.rdata = q.wr ? q.wdata : ln_data;
                        if (q.wr) begin
                            wr_en    = 1'b1;
                            wr_state = LN_EXC;
                            wr_tag   = req_tag;
                            wr_data  = q.wdata;
                        end
                    end else if (!hit && ln_state == LN_EXC) begin
                        d.st = PS_WBREQ;
                    end else begin
                        d.st = PS_MISSREQ;
                    end
                end
            end
            PS_WBREQ: begin
                bus_req = 1'b1;
                if (restart) begin
                    d.st = PS_LOOKUP;
                end else if (bus_gnt) begin
                    bus_cmd   = BC_WBACK;
                    bus_addr  = {ln_tag, look_idx};
                    bus_wdata = ln_data;
                    wr_en     = 1'b1;
                    wr_state  = LN_INV;
                    d.st      = PS_LOOKUP;
                end
            end
            PS_MISSREQ: begin
                bus_req = 1'b1;
                if (restart) begin
                    d.st = PS_LOOKUP;
                end else if (bus_gnt) begin
                    bus_cmd  = q.wr ? BC_WRMISS : BC_RDMISS;
                    bus_addr = q.addr;
                    wr_en    = 1'b1;
                    wr_tag   = req_tag;
                    wr_state = q.wr ? LN_EXC : LN_SHR;
                    wr_data  = q.wr ? q.wdata : bus_rdata;
                    d.rdata  = q.wr ? q.wdata : bus_rdata;
                    d.resp   = 1'b1;
                    d.st     = PS_IDLE;
                end
            end
            default: d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: PS_IDLE, wr: 1'b0, addr: '0, wdata: '0, resp: 1'b0, rdata: '0};
        end else begin
            q <= d;
        end
    end

    assign cpu_resp_valid = q.resp;
    assign cpu_resp_rdata = q.rdata;

    // R11: a completion is a single-cycle pulse
    assert_resp_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        q.resp |=> !q.resp);

    // R10: a snoop in the lookup cycle holds the processor lookup back
    assert_lookup_waits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_LOOKUP && snoop_busy) |=> (q.st == PS_LOOKUP && !q.resp));

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req_valid,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_req_ready,
    output logic              cpu_resp_valid,
    output logic [DATA_W-1:0] cpu_resp_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              snoop_supply,
    output logic [DATA_W-1:0] snoop_data
);
    localparam int TAG_W = ADDR_W - IDX_W;

    bus_cmd_e          snp_cmd;
    logic              snoop_busy;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;

    line_state_e       a_state, b_state;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;
    logic [IDX_W-1:0]  look_idx;

    logic              snp_upd;
    line_state_e       snp_state;

    logic              p_wr_en;
    line_state_e       p_wr_state;
    logic [TAG_W-1:0]  p_wr_tag;
    logic [DATA_W-1:0] p_wr_data;
    bus_cmd_e          p_cmd;

    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    line_state_e       wr_state;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] wr_data;

    assign snp_cmd    = bus_cmd_e'(snoop_cmd);
    assign snoop_busy = (snp_cmd != BC_NONE);
    assign snp_idx    = snoop_addr[IDX_W-1:0];
    assign snp_tag    = snoop_addr[ADDR_W-1:IDX_W];

    msi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_idx    (look_idx),
        .a_state  (a_state),
        .a_tag    (a_tag),
        .a_data   (a_data),
        .b_idx    (snp_idx),
        .b_state  (b_state),
        .b_tag    (b_tag),
        .b_data   (b_data),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_state (wr_state),
        .wr_tag   (wr_tag),
        .wr_data  (wr_data)
    );

    msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_cmd   (snp_cmd),
        .snp_tag   (snp_tag),
        .ln_state  (b_state),
        .ln_tag    (b_tag),
        .ln_data   (b_data),
        .upd_en    (snp_upd),
        .upd_state (snp_state),
        .supply    (snoop_supply),
        .sup_data  (snoop_data)
    );

    msi_proc_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_wdata  (cpu_req_wdata),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata),
        .snoop_busy     (snoop_busy),
        .snoop_upd      (snp_upd),
        .snoop_idx      (snp_idx),
        .look_idx       (look_idx),
        .ln_state       (a_state),
        .ln_tag         (a_tag),
        .ln_data        (a_data),
        .bus_gnt        (bus_gnt),
        .bus_rdata      (bus_rdata),
        .bus_req        (bus_req),
        .bus_cmd        (p_cmd),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .wr_en          (p_wr_en),
        .wr_state       (p_wr_state),
        .wr_tag         (p_wr_tag),
        .wr_data        (p_wr_data)
    );

    assign bus_cmd = p_cmd;

    // snoop side owns the write port whenever it changes a line
    always_comb begin
        if (snp_upd) begin
            wr_en    = 1'b1;
            wr_idx   = snp_idx;
            wr_state = snp_state;
            wr_tag   = b_tag;
            wr_data  = b_data;
        end else begin
            wr_en    = p_wr_en;
            wr_idx   = look_idx;
            wr_state = p_wr_state;
            wr_tag   = p_wr_tag;
            wr_data  = p_wr_data;
        end
    end

    // R12: a command is only driven while owning the bus
    assert_cmd_on_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'b00) |-> (bus_req && bus_gnt));

    // R12: a waiting request is held unless a snoop intervenes
    assert_req_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && snoop_cmd == 2'b00) |=> bus_req);

    // R12: atomic bus, no grant alongside another agent's transaction
    assert_no_grant_in_snoop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt) |-> (snoop_cmd == 2'b00));

    // R10: snoops block acceptance of processor requests
    assert_ready_low_on_snoop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (snoop_cmd != 2'b00) |-> !cpu_req_ready);

    // R7: data is supplied only in answer to a snooped miss
    assert_supply_on_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_supply |-> (snoop_cmd == 2'b01 || snoop_cmd == 2'b10));

endmodule

// File: tb/msi_snoop_ctrl_tb.sv
module msi_snoop_ctrl_tb;

    localparam int AW = 8;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_write = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_req_ready;
    logic          cpu_resp_valid;
    logic [DW-1:0] cpu_resp_rdata;
    logic          bus_req;
    logic          bus_gnt = 1'b0;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic [1:0]    snoop_cmd = 2'b00;
    logic [AW-1:0] snoop_addr = '0;
    logic          snoop_supply;
    logic [DW-1:0] snoop_data;

    always #2 clk = ~clk;

    msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(2), .DATA_W(DW)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cpu_req_valid  (cpu_req_valid),
        .cpu_req_write  (cpu_req_write),
        .cpu_req_addr   (cpu_req_addr),
        .cpu_req_wdata  (cpu_req_wdata),
        .cpu_req_ready  (cpu_req_ready),
        .cpu_resp_valid (cpu_resp_valid),
        .cpu_resp_rdata (cpu_resp_rdata),
        .bus_req        (bus_req),
        .bus_gnt        (bus_gnt),
        .bus_cmd        (bus_cmd),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .snoop_cmd      (snoop_cmd),
        .snoop_addr     (snoop_addr),
        .snoop_supply   (snoop_supply),
        .snoop_data     (snoop_data)
    );

    localparam logic [1:0] C_NONE = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_WB = 2'b11;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [1:0]    tx_cmd  [4];
    logic [AW-1:0] tx_addr [4];
    logic [DW-1:0] tx_data [4];
    int            n_tx;
    logic [DW-1:0] got_rdata;
    bit            got_resp;
    logic          s_sup;
    logic [DW-1:0] s_dat;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // one processor operation; acts as arbiter, optionally snoops once while waiting
    task automatic run_op(input bit wr, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                          input logic [DW-1:0] fill, input int gnt_delay,
                          input logic [1:0] s_cmd, input logic [AW-1:0] s_addr);
        int  wait_cnt;
        bit  s_done;
        bit  was_waiting;
        n_tx = 0; got_resp = 1'b0; s_sup = 1'b0; s_dat = '0;
        wait_cnt = 0; s_done = 1'b0; was_waiting = 1'b0;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = addr; cpu_req_wdata = wd;
        #1;
        for (int k = 0; k < 20 && !cpu_req_ready; k++) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        cpu_req_valid = 1'b0;
        for (int c = 0; c < 60 && !got_resp; c++) begin
            if (c != 0) @(negedge clk);
            bus_gnt = 1'b0; snoop_cmd = C_NONE;
            #1;
            if (was_waiting && !s_done)
                check(bus_req == 1'b1, "R12 request held", {31'b0, bus_req}, 32'd1);
            was_waiting = 1'b0;
            if (cpu_resp_valid) begin
                got_resp = 1'b1; got_rdata = cpu_resp_rdata;
            end else if (bus_req) begin
                check(bus_cmd == C_NONE, "R12 no command before grant", {30'b0, bus_cmd}, 32'd0);
                if (s_cmd != C_NONE && !s_done) begin
                    snoop_cmd = s_cmd; snoop_addr = s_addr;
                    #1;
                    s_sup = snoop_supply; s_dat = snoop_data; s_done = 1'b1;
                end else if (wait_cnt >= gnt_delay) begin
                    bus_gnt = 1'b1; bus_rdata = fill;
                    #1;
                    if (n_tx < 4) begin
                        tx_cmd[n_tx] = bus_cmd; tx_addr[n_tx] = bus_addr; tx_data[n_tx] = bus_wdata;
                    end
                    n_tx++; wait_cnt = 0;
                end else begin
                    wait_cnt++; was_waiting = 1'b1;
                end
            end
        end
        @(negedge clk);
        bus_gnt = 1'b0; snoop_cmd = C_NONE;
        check(got_resp, "op completes", {31'b0, got_resp}, 32'd1);
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] addr);
        @(negedge clk);
        snoop_cmd = cmd; snoop_addr = addr;
        #1;
        s_sup = snoop_supply; s_dat = snoop_data;
        check(cpu_req_ready == 1'b0, "R10 ready low during snoop", {31'b0, cpu_req_ready}, 32'd0);
        @(negedge clk);
        snoop_cmd = C_NONE;
    endtask

    task automatic expect_one_tx(input string req, input logic [1:0] cmd, input logic [AW-1:0] a);
        check(n_tx == 1, req, n_tx, 32'd1);
        check(tx_cmd[0] == cmd, req, {30'b0, tx_cmd[0]}, {30'b0, cmd});
        check(tx_addr[0] == a, req, {24'b0, tx_addr[0]}, {24'b0, a});
    endtask

    task automatic test_reset;
        #1;
        check(cpu_req_ready == 1'b1, "R1 ready after reset", {31'b0, cpu_req_ready}, 32'd1);
        check(bus_req == 1'b0, "R1 no bus request", {31'b0, bus_req}, 32'd0);
        check(cpu_resp_valid == 1'b0, "R1 no response", {31'b0, cpu_resp_valid}, 32'd0);
        check(snoop_supply == 1'b0, "R1 no supply", {31'b0, snoop_supply}, 32'd0);
    endtask

    task automatic test_read_miss_and_hit;
        run_op(1'b0, 8'h10, '0, 16'h1234, 0, C_NONE, '0);
        expect_one_tx("R2 read miss from Invalid", C_RD, 8'h10);
        check(got_rdata == 16'h1234, "R2 fill data", got_rdata, 16'h1234);
        run_op(1'b0, 8'h10, '0, 16'hFFFF, 0, C_NONE, '0);
        check(n_tx == 0, "R11 read hit in Shared no bus", n_tx, 0);
        check(got_rdata == 16'h1234, "R11 read hit data", got_rdata, 16'h1234);
    endtask

    task automatic test_upgrade;
        run_op(1'b1, 8'h10, 16'hBEEF, '0, 0, C_NONE, '0);
        expect_one_tx("R4 write to Shared issues write miss", C_WR, 8'h10);
        run_op(1'b1, 8'h10, 16'hCAFE, '0, 0, C_NONE, '0);
        check(n_tx == 0, "R11 write hit in Exclusive no bus", n_tx, 0);
        run_op(1'b0, 8'h10, '0, '0, 0, C_NONE, '0);
        check(n_tx == 0, "R11 read hit in Exclusive no bus", n_tx, 0);
        check(got_rdata == 16'hCAFE, "R4 data held", got_rdata, 16'hCAFE);
    endtask

    task automatic test_write_miss;
        run_op(1'b1, 8'h21, 16'h5555, '0, 0, C_NONE, '0);
        expect_one_tx("R3 write miss from Invalid", C_WR, 8'h21);
        run_op(1'b0, 8'h21, '0, '0, 0, C_NONE, '0);
        check(n_tx == 0 && got_rdata == 16'h5555, "R3 line Exclusive with data", got_rdata, 16'h5555);
    endtask

    task automatic test_victim;
        run_op(1'b0, 8'h14, '0, 16'h7777, 0, C_NONE, '0);
        check(n_tx == 2, "R5 two transactions", n_tx, 2);
        check(tx_cmd[0] == C_WB && tx_addr[0] == 8'h10 && tx_data[0] == 16'hCAFE,
              "R5 write-back of victim", {tx_cmd[0], tx_addr[0], tx_data[0]}, {2'b11, 8'h10, 16'hCAFE});
        check(tx_cmd[1] == C_RD && tx_addr[1] == 8'h14, "R5 then read miss",
              {22'b0, tx_cmd[1], tx_addr[1]}, {22'b0, 2'b01, 8'h14});
        check(got_rdata == 16'h7777, "R5 fill data", got_rdata, 16'h7777);
    endtask

    task automatic test_snoop_shared_inv;
        snoop(C_WR, 8'h14);
        check(s_sup == 1'b0, "R6 no supply from Shared", {31'b0, s_sup}, 32'd0);
        run_op(1'b0, 8'h14, '0, 16'h8888, 0, C_NONE, '0);
        expect_one_tx("R6 line invalidated", C_RD, 8'h14);
    endtask

    task automatic test_snoop_excl;
        snoop(C_RD, 8'h21);
        check(s_sup == 1'b1 && s_dat == 16'h5555, "R7 supply on read snoop", {s_sup, s_dat}, {1'b1, 16'h5555});
        run_op(1'b0, 8'h21, '0, '0, 0, C_NONE, '0);
        check(n_tx == 0 && got_rdata == 16'h5555, "R7 line kept readable", got_rdata, 16'h5555);
        run_op(1'b1, 8'h21, 16'h6666, '0, 0, C_NONE, '0);
        expect_one_tx("R7 line downgraded to Shared", C_WR, 8'h21);
        snoop(C_WR, 8'h21);
        check(s_sup == 1'b1 && s_dat == 16'h6666, "R8 supply on write snoop", {s_sup, s_dat}, {1'b1, 16'h6666});
        run_op(1'b0, 8'h21, '0, 16'h9999, 0, C_NONE, '0);
        expect_one_tx("R8 line invalidated", C_RD, 8'h21);
    endtask

    task automatic test_snoop_ignored;
        snoop(C_WR, 8'h25);
        check(s_sup == 1'b0, "R13 tag mismatch no supply", {31'b0, s_sup}, 32'd0);
        snoop(C_RD, 8'h21);
        check(s_sup == 1'b0, "R13 read snoop on Shared no supply", {31'b0, s_sup}, 32'd0);
        run_op(1'b0, 8'h21, '0, '0, 0, C_NONE, '0);
        check(n_tx == 0 && got_rdata == 16'h9999, "R13 line unchanged", got_rdata, 16'h9999);
    endtask

    task automatic test_restart;
        run_op(1'b1, 8'h32, 16'hAAAA, '0, 0, C_NONE, '0);
        run_op(1'b0, 8'h36, '0, 16'h4444, 0, C_RD, 8'h32);
        check(s_sup == 1'b1 && s_dat == 16'hAAAA, "R9 snoop served while waiting", {s_sup, s_dat}, {1'b1, 16'hAAAA});
        expect_one_tx("R9 write-back skipped after restart", C_RD, 8'h36);
        check(got_rdata == 16'h4444, "R9 fill after restart", got_rdata, 16'h4444);
        run_op(1'b0, 8'h03, '0, 16'h0303, 0, C_NONE, '0);
        run_op(1'b1, 8'h03, 16'h3333, '0, 0, C_WR, 8'h03);
        check(s_sup == 1'b0, "R9 Shared target invalidated", {31'b0, s_sup}, 32'd0);
        expect_one_tx("R9 write miss reissued", C_WR, 8'h03);
        run_op(1'b0, 8'h03, '0, '0, 0, C_NONE, '0);
        check(n_tx == 0 && got_rdata == 16'h3333, "R9 line Exclusive after restart", got_rdata, 16'h3333);
    endtask

    task automatic test_priority;
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h03;
        snoop_cmd = C_RD; snoop_addr = 8'h3A;
        #1;
        check(cpu_req_ready == 1'b0, "R10 snoop wins over request", {31'b0, cpu_req_ready}, 32'd0);
        @(negedge clk);
        snoop_cmd = C_NONE; cpu_req_valid = 1'b0;
        run_op(1'b0, 8'h03, '0, '0, 0, C_NONE, '0);
        check(n_tx == 0 && got_rdata == 16'h3333, "R10 request served after snoop", got_rdata, 16'h3333);
    endtask

    task automatic test_delayed_grant;
        run_op(1'b0, 8'h07, '0, 16'h0707, 3, C_NONE, '0);
        check(n_tx == 2, "R12 delayed grant transactions", n_tx, 2);
        check(tx_cmd[0] == C_WB && tx_data[0] == 16'h3333, "R12 write-back after wait",
              {14'b0, tx_cmd[0], tx_data[0]}, {14'b0, 2'b11, 16'h3333});
        check(tx_cmd[1] == C_RD && tx_addr[1] == 8'h07, "R12 miss after wait",
              {22'b0, tx_cmd[1], tx_addr[1]}, {22'b0, 2'b01, 8'h07});
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_read_miss_and_hit();
        test_upgrade();
        test_write_miss();
        test_victim();
        test_snoop_shared_inv();
        test_snoop_excl();
        test_snoop_ignored();
        test_restart();
        test_priority();
        test_delayed_grant();
        report();
    end

endmodule